// File: doc/BRIEF.md
# Bridge Command and Status Configuration Registers

This block holds the two 16-bit configuration words that control a bridge function and report errors from it: a command word with two writable enable bits, and a status word with sticky error flags. Software reaches both words through a small configuration port made of a byte address, byte-lane enables, write data, a write strobe and a read strobe. Read data is combinational and is valid while the read strobe is high.

The bridge datapath sends single-cycle event pulses into the block. These report a detected parity error, a received completion with unsupported-request status, and a received completion with completer-abort status. Each pulse latches its own status flag. The flag stays set until software writes a 1 to that bit position.

A parity error can also raise a one-cycle system-error pulse. This happens only when both the parity-response enable and the system-error enable are set. Whenever that pulse is raised, its own status flag is recorded as well.

Top module: `pci_cmdsts`

## Requirements
- R1: After reset the command word reads 0x0007, the status word reads 0x0210, and `serr_o` is 0.
- R2: Command bits 2:0 always read as 1, including after a write of 0 to them.
- R3: Command bit 6 (parity-response enable) and bit 8 (system-error enable) hold the value last written. Every other command bit above bit 2 reads 0, so a write of 0xFFFF reads back as 0x0147.
- R4: A write changes only bits in lanes whose byte enable is 1: lane 0 holds bits 7:0 and lane 1 holds bits 15:8.
- R5: A `perr_evt` pulse sets status bit 15 from the next clock, even when command bit 6 is 0.
- R6: A `ur_cpl_evt` pulse sets status bit 13, and a `ca_cpl_evt` pulse sets status bit 12, each from the next clock.
- R7: Status bits 15:12 are cleared by writing 1 to them. Writing 0 leaves them unchanged. Bits 9 and 4 always read as 1, and all other status bits read as 0.
- R8: `serr_o` is high for exactly the one cycle after a `perr_evt` pulse, and only when command bits 6 and 8 were both 1 in the event cycle.
- R9: Status bit 14 is set on the same clock edge on which `serr_o` rises, and on no other condition.
- R10: When a set event and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R11: `cfg_rdata` is 0 when `cfg_rd` is low, and also when the address is neither 0x04 nor 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | 8 | Byte address of the register word |
| cfg_be | input | 2 | Byte-lane write enables |
| cfg_wdata | input | 16 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 16 | Read data |
| perr_evt | input | 1 | Parity error detected pulse |
| ur_cpl_evt | input | 1 | Unsupported-request completion pulse |
| ca_cpl_evt | input | 1 | Completer-abort completion pulse |
| serr_o | output | 1 | System-error pulse |

## Verification
Parity events are driven under each of the four combinations of the two enables. This separates recording the flag, which happens always, from signalling the error, which happens only when both enables are 1. Writes of all-ones and all-zeros, each with single-lane byte enables, separate the writable bits from the hardwired ones and show whether lane gating works. The status word is then cleared in several ways: with matching ones, with zeros, and in the same cycle as a new event. This shows whether the flags are sticky and whether a set beats a clear.

// File: rtl/pci_cmdsts_pkg.sv
package pci_cmdsts_pkg;
    localparam int REG_W  = 16;
    localparam int LANE_W = 8;
    localparam int BE_W   = REG_W / LANE_W;

    // command bit positions
    localparam int CMD_PERR_RSP = 6;
    localparam int CMD_SERR_EN  = 8;
    // status bit positions
    localparam int STS_DPE = 15;
    localparam int STS_SSE = 14;
    localparam int STS_URC = 13;
    localparam int STS_CAC = 12;

    localparam logic [REG_W-1:0] CMD_ONES = 16'h0007;
    localparam logic [REG_W-1:0] STS_ONES = 16'h0210;

    typedef struct packed {
        logic serr_en;
        logic perr_rsp;
    } cmd_state_t;

    typedef struct packed {
        logic dpe;
        logic sse;
        logic urc;
        logic cac;
    } sts_state_t;
endpackage

// File: rtl/pci_cmdsts_access.sv
module pci_cmdsts_access
    import pci_cmdsts_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h06
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [REG_W-1:0]  cmd_word,
    input  logic [REG_W-1:0]  sts_word,
    output logic [BE_W-1:0]   cmd_lane_we,
    output logic [BE_W-1:0]   sts_lane_we,
    output logic [REG_W-1:0]  rdata
);
    logic cmd_hit;
    logic sts_hit;

    always_comb begin
        cmd_hit = (cfg_addr == CMD_ADDR);
        sts_hit = (cfg_addr == STS_ADDR);
    end

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        always_comb begin
            cmd_lane_we[g] = cfg_wr && cmd_hit && cfg_be[g];
            sts_lane_we[g] = cfg_wr && sts_hit && cfg_be[g];
        end
    end

    always_comb begin
        rdata = '0;
        if (cfg_rd) begin
            if (cmd_hit)      rdata = cmd_word;
            else if (sts_hit) rdata = sts_word;
        end
    end
endmodule

// File: rtl/pci_cmdsts_cmd_reg.sv
module pci_cmdsts_cmd_reg
    import pci_cmdsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BE_W-1:0]  lane_we,
    input  logic             wd_perr_rsp,
    input  logic             wd_serr_en,
    output logic             perr_rsp,
    output logic             serr_en,
    output logic [REG_W-1:0] cmd_word
);
    localparam int PERR_LANE = CMD_PERR_RSP / LANE_W;
    localparam int SERR_LANE = CMD_SERR_EN / LANE_W;

    cmd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (lane_we[PERR_LANE]) state_d.perr_rsp = wd_perr_rsp;
        if (lane_we[SERR_LANE]) state_d.serr_en  = wd_serr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_word               = CMD_ONES;
        cmd_word[CMD_PERR_RSP] = state_q.perr_rsp;
        cmd_word[CMD_SERR_EN]  = state_q.serr_en;
        perr_rsp               = state_q.perr_rsp;
        serr_en                = state_q.serr_en;
    end

    // R4: a lane left disabled keeps its bit
    a_r4_lane0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[PERR_LANE] |=> $stable(perr_rsp));
    a_r4_lane1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[SERR_LANE] |=> $stable(serr_en));
endmodule

// File: rtl/pci_cmdsts_sts_reg.sv
module pci_cmdsts_sts_reg
    import pci_cmdsts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BE_W-1:0]  lane_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             perr_evt,
    input  logic             ur_cpl_evt,
    input  logic             ca_cpl_evt,
    input  logic             serr_fire,
    output logic [REG_W-1:0] sts_word
);
    localparam int FLAG_LANE = STS_DPE / LANE_W;

    sts_state_t state_d, state_q;
    logic clr_dpe, clr_sse, clr_urc, clr_cac;

    always_comb begin
        clr_dpe = lane_we[FLAG_LANE] && wdata[STS_DPE];
        clr_sse = lane_we[FLAG_LANE] && wdata[STS_SSE];
        clr_urc = lane_we[FLAG_LANE] && wdata[STS_URC];
        clr_cac = lane_we[FLAG_LANE] && wdata[STS_CAC];
        // set beats clear so no event is lost
        state_d.dpe = perr_evt   || (state_q.dpe && !clr_dpe);
        state_d.sse = serr_fire  || (state_q.sse && !clr_sse);
        state_d.urc = ur_cpl_evt || (state_q.urc && !clr_urc);
        state_d.cac = ca_cpl_evt || (state_q.cac && !clr_cac);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        sts_word          = STS_ONES;
        sts_word[STS_DPE] = state_q.dpe;
        sts_word[STS_SSE] = state_q.sse;
        sts_word[STS_URC] = state_q.urc;
        sts_word[STS_CAC] = state_q.cac;
    end

    a_r5_dpe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |=> sts_word[STS_DPE]);
    a_r6_urc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ur_cpl_evt |=> sts_word[STS_URC]);
    a_r6_cac_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ca_cpl_evt |=> sts_word[STS_CAC]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sts_word[STS_CAC] && !clr_cac |=> sts_word[STS_CAC]);
    a_r7_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_urc && !ur_cpl_evt |=> !sts_word[STS_URC]);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dpe && perr_evt |=> sts_word[STS_DPE]);
endmodule

// File: rtl/pci_cmdsts_serr_gen.sv
module pci_cmdsts_serr_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic perr_evt,
    input  logic perr_rsp,
    input  logic serr_en,
    output logic serr_fire,
    output logic serr_o
);
    logic serr_d, serr_q;

    always_comb begin
        serr_d    = perr_evt && perr_rsp && serr_en;
        serr_fire = serr_d;
        serr_o    = serr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) serr_q <= 1'b0;
        else        serr_q <= serr_d;
    end

    a_r8_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(perr_evt));
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> $past(serr_en));
endmodule

// File: rtl/pci_cmdsts.sv
module pci_cmdsts
    import pci_cmdsts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 'h04,
    parameter logic [ADDR_W-1:0] STS_ADDR = 'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              perr_evt,
    input  logic              ur_cpl_evt,
    input  logic              ca_cpl_evt,
    output logic              serr_o
);
    logic [BE_W-1:0]  cmd_lane_we, sts_lane_we;
    logic [REG_W-1:0] cmd_word, sts_word;
    logic             perr_rsp, serr_en, serr_fire;

    pci_cmdsts_access #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STS_ADDR(STS_ADDR)
    ) u_access (
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cmd_word(cmd_word), .sts_word(sts_word),
        .cmd_lane_we(cmd_lane_we), .sts_lane_we(sts_lane_we), .rdata(cfg_rdata)
    );

    pci_cmdsts_cmd_reg u_cmd (
        .clk(clk), .rst_n(rst_n), .lane_we(cmd_lane_we),
        .wd_perr_rsp(cfg_wdata[CMD_PERR_RSP]), .wd_serr_en(cfg_wdata[CMD_SERR_EN]),
        .perr_rsp(perr_rsp), .serr_en(serr_en), .cmd_word(cmd_word)
    );

    pci_cmdsts_serr_gen u_serr (
        .clk(clk), .rst_n(rst_n), .perr_evt(perr_evt), .perr_rsp(perr_rsp),
        .serr_en(serr_en), .serr_fire(serr_fire), .serr_o(serr_o)
    );

    pci_cmdsts_sts_reg u_sts (
        .clk(clk), .rst_n(rst_n), .lane_we(sts_lane_we), .wdata(cfg_wdata),
        .perr_evt(perr_evt), .ur_cpl_evt(ur_cpl_evt), .ca_cpl_evt(ca_cpl_evt),
        .serr_fire(serr_fire), .sts_word(sts_word)
    );

    // R9: the pulse and its status flag appear together
    a_r9_sse_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> sts_word[STS_SSE]);
    // R2: low command bits stay fixed
    a_r2_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_word[2:0] == 3'b111);
endmodule

// File: tb/pci_cmdsts_bench.sv
module pci_cmdsts_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [15:0] cfg_rdata;
    logic        perr_evt = 1'b0, ur_cpl_evt = 1'b0, ca_cpl_evt = 1'b0;
    logic        serr_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cmdsts u_pci_cmdsts (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .perr_evt(perr_evt), .ur_cpl_evt(ur_cpl_evt),
        .ca_cpl_evt(ca_cpl_evt), .serr_o(serr_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        cfg_addr = a; cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        cfg_rd = 1'b0;
    endtask

    task automatic pulse(input logic p, input logic u, input logic c);
        @(negedge clk);
        perr_evt = p; ur_cpl_evt = u; ca_cpl_evt = c;
        @(negedge clk);
        perr_evt = 0; ur_cpl_evt = 0; ca_cpl_evt = 0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(8'h04, v); check("R1 cmd reset", v, 16'h0007);
        rd(8'h06, v); check("R1 sts reset", v, 16'h0210);
        check("R1 serr reset", {15'd0, serr_o}, 16'h0000);
    endtask

    task automatic t_cmd_bits();
        logic [15:0] v;
        wr(8'h04, 2'b11, 16'hFFFF);
        rd(8'h04, v); check("R3 all ones", v, 16'h0147);
        wr(8'h04, 2'b11, 16'h0000);
        rd(8'h04, v); check("R2 low bits after zero write", v, 16'h0007);
    endtask

    task automatic t_byte_en();
        logic [15:0] v;
        wr(8'h04, 2'b01, 16'hFFFF);
        rd(8'h04, v); check("R4 lane0 only", v, 16'h0047);
        wr(8'h04, 2'b10, 16'hFFFF);
        rd(8'h04, v); check("R4 lane1 adds", v, 16'h0147);
        wr(8'h04, 2'b01, 16'h0000);
        rd(8'h04, v); check("R4 lane0 clear keeps lane1", v, 16'h0107);
        wr(8'h04, 2'b00, 16'h0000);
        rd(8'h04, v); check("R4 no lanes", v, 16'h0107);
        wr(8'h04, 2'b11, 16'h0000);
    endtask

    task automatic t_perr_disabled();
        logic [15:0] v;
        // four enable combinations, serr only for both set
        for (int k = 0; k < 4; k++) begin
            wr(8'h04, 2'b11, {7'd0, k[1], 1'b0, k[0], 6'd0});
            @(negedge clk);
            perr_evt = 1'b1;
            @(negedge clk);
            perr_evt = 1'b0;
            check("R8 serr per enables", {15'd0, serr_o}, {15'd0, (k == 3)});
            rd(8'h06, v);
            check("R5 dpe set", {15'd0, v[15]}, 16'h0001);
            check("R9 sse follows serr", {15'd0, v[14]}, {15'd0, (k == 3)});
            @(negedge clk);
            check("R8 single cycle", {15'd0, serr_o}, 16'h0000);
            wr(8'h06, 2'b10, 16'hF000);
            rd(8'h06, v); check("R7 clear all flags", v, 16'h0210);
        end
        wr(8'h04, 2'b11, 16'h0000);
    endtask

    task automatic t_completions();
        logic [15:0] v;
        pulse(1'b0, 1'b1, 1'b0);
        rd(8'h06, v); check("R6 urc", v, 16'h2210);
        pulse(1'b0, 1'b0, 1'b1);
        rd(8'h06, v); check("R6 cac", v, 16'h3210);
        check("R9 no serr from completions", {15'd0, serr_o}, 16'h0000);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        wr(8'h06, 2'b11, 16'h0000);
        rd(8'h06, v); check("R7 zero write keeps", v, 16'h3210);
        wr(8'h06, 2'b11, 16'h1000);
        rd(8'h06, v); check("R7 clear cac only", v, 16'h2210);
        wr(8'h06, 2'b01, 16'hFFFF);
        rd(8'h06, v); check("R7 lane0 no clear", v, 16'h2210);
        wr(8'h06, 2'b11, 16'hFFFF);
        rd(8'h06, v); check("R7 fixed bits stay", v, 16'h0210);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        @(negedge clk);
        cfg_addr = 8'h06; cfg_be = 2'b10; cfg_wdata = 16'h8000; cfg_wr = 1'b1;
        perr_evt = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; perr_evt = 1'b0; cfg_be = '0;
        rd(8'h06, v); check("R10 set wins", v, 16'h8210);
        wr(8'h06, 2'b10, 16'h8000);
        rd(8'h06, v); check("R10 later clear", v, 16'h0210);
    endtask

    task automatic t_decode();
        logic [15:0] v;
        rd(8'h08, v); check("R11 other addr", v, 16'h0000);
        rd(8'h05, v); check("R11 odd addr", v, 16'h0000);
        cfg_addr = 8'h04; cfg_rd = 1'b0;
        #1 check("R11 no strobe", cfg_rdata, 16'h0000);
        wr(8'h08, 2'b11, 16'hFFFF);
        rd(8'h04, v); check("R11 stray write cmd", v, 16'h0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_bits();
        t_byte_en();
        t_perr_disabled();
        t_completions();
        t_w1c();
        t_set_wins();
        t_decode();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule